// File: doc/BRIEF.md
# Generalized Parallel Counter Set

This block is a family of generalized parallel counters for compressor trees. Each counter collects bits from up to four adjacent columns of a bit heap, counts the ones in each column, weights column j by 2^j and presents the total as a 5-bit binary word. The counter that gets built is chosen at elaboration by a parameter. The choices are the (6,0,6;5), (1,4,1,5;5) and (1,3,2,5;5) counters and a one-in, one-out pass-through. In counter notation the input counts per column are listed from the most significant column down, and the output width follows the semicolon.

Every column has its own packed input port, sized for the widest column that any variant uses. A variant reads only the low bits of each column that it needs. The pass-through does no compression. Built combinationally it acts as a wire. Built with the output register it acts as a pipeline-balancing flip-flop that keeps a bit in step with neighbouring counters. A second parameter places a register on the sum so that a tree can be pipelined one stage per counter level.

Top module: `gpc_counter`

## Requirements
- R1: With KIND = GPC_606 (code 0), sum_o = popcount(col0_i[5:0]) + 4·popcount(col2_i[5:0]).
- R2: With KIND = GPC_1415 (code 1), sum_o = popcount(col0_i[4:0]) + 2·col1_i[0] + 4·popcount(col2_i[3:0]) + 8·col3_i[0].
- R3: With KIND = GPC_1325 (code 2), sum_o = popcount(col0_i[4:0]) + 2·popcount(col1_i[1:0]) + 4·popcount(col2_i[2:0]) + 8·col3_i[0].
- R4: With KIND = GPC_PASS (code 3), sum_o[0] follows col0_i[0] and sum_o[4:1] is zero.
- R5: Input bits outside the ranges named in R1 to R4 for the selected KIND have no effect on sum_o. For GPC_606 these are col1_i and col3_i. For GPC_1415 they are col0_i[5], col1_i[1] and col2_i[5:4]. For GPC_1325 they are col0_i[5] and col2_i[5:3]. For GPC_PASS they are every bit except col0_i[0].
- R6: With REGISTERED = 0, sum_o reflects the current inputs in the same cycle, with no clock edge between them.
- R7: With REGISTERED = 1, sum_o after a rising edge with rst_n high equals the sum of the inputs sampled at that edge. The result is therefore valid exactly one cycle after the inputs.
- R8: With REGISTERED = 1, a rising edge with rst_n low sets sum_o to zero, whatever the inputs are.
- R9: sum_o never exceeds the variant's maximum: 30 for GPC_606, 31 for GPC_1415, 29 for GPC_1325 and 1 for GPC_PASS. All-ones inputs reach exactly that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| col0_i | input | COL0_W (6) | Bits of weight 1 |
| col1_i | input | COL1_W (2) | Bits of weight 2 |
| col2_i | input | COL2_W (6) | Bits of weight 4 |
| col3_i | input | COL3_W (1) | Bits of weight 8 |
| sum_o | output | SUM_W (5) | Weighted count of the used input bits |

## Verification
The bench goes after the per-variant column masks. It sets only the bits that a variant must ignore. A counter that reads a column too wide or sits on the wrong column would return a non-zero sum, and one that drops a needed bit would come up short on the all-ones maximum of 30, 31 or 29. Random vectors, fed at once to every variant, catch a column weighted by the wrong power of two. The registered instances are checked one cycle later and during a reset held in mid-run with all inputs high. A register that leaks the inputs through, lags by a further stage or resets asynchronously would show a wrong or mistimed value.

// File: rtl/gpc_pkg.sv
// Package gpc_pkg
// Shared definitions for the generalized parallel counter set: the
// variant code and elaboration-time helpers that give, for each variant,
// how many bits of each column are summed and the largest possible sum.
// Assumes columns are numbered from the least significant (weight 1).
package gpc_pkg;

    typedef enum logic [1:0] {
        GPC_606  = 2'd0,
        GPC_1415 = 2'd1,
        GPC_1325 = 2'd2,
        GPC_PASS = 2'd3
    } gpc_kind_e;

    localparam int NUM_COLS = 4;

    // Number of bits of column 'col' that variant 'k' adds up.
    function automatic int used_bits(gpc_kind_e k, int col);
        int n;
        n = 0;
        case (k)
            GPC_606: begin
                if (col == 0 || col == 2) n = 6;
            end
            GPC_1415: begin
                case (col)
                    0: n = 5;
                    1: n = 1;
                    2: n = 4;
                    3: n = 1;
                    default: n = 0;
                endcase
            end
            GPC_1325: begin
                case (col)
                    0: n = 5;
                    1: n = 2;
                    2: n = 3;
                    3: n = 1;
                    default: n = 0;
                endcase
            end
            default: begin
                if (col == 0) n = 1;
            end
        endcase
        return n;
    endfunction

    // Largest weighted sum the variant can produce.
    function automatic int max_sum(gpc_kind_e k);
        int s;
        s = 0;
        for (int c = 0; c < NUM_COLS; c++) begin
            s = s + (used_bits(k, c) << c);
        end
        return s;
    endfunction

    // Width needed to hold a count of 0..n (at least one bit).
    function automatic int cnt_width(int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/gpc_col_pop.sv
// Module gpc_col_pop
// Counts the ones among the low USE_W bits of one column input.
// Bits above USE_W are ignored. USE_W may be zero, in which case
// the count is constant zero. Assumes USE_W <= IN_W.
module gpc_col_pop #(
    parameter int IN_W  = 6,
    parameter int USE_W = 6,
    parameter int CNT_W = 3
) (
    input  logic [IN_W-1:0]  bits_i,
    output logic [CNT_W-1:0] cnt_o
);

    generate
        if (USE_W == 0) begin : g_empty
            // Empty column: nothing is counted.
            logic unused_col;
            assign unused_col = ^bits_i;
            assign cnt_o = '0;
        end else begin : g_count
            // Population count of the used bits.
            always_comb begin
                cnt_o = '0;
                for (int i = 0; i < USE_W; i++) begin
                    cnt_o = cnt_o + CNT_W'(bits_i[i]);
                end
            end
            if (USE_W < IN_W) begin : g_mask
                // Bits beyond the used range are deliberately left out.
                logic unused_hi;
                assign unused_hi = ^bits_i[IN_W-1:USE_W];
            end
        end
    endgenerate

endmodule

// File: rtl/gpc_weight_add.sv
// Module gpc_weight_add
// Combines the four column counts into one binary word, shifting the
// count of column j left by j places. Assumes the caller has chosen
// SUM_W large enough that the weighted total cannot overflow.
module gpc_weight_add #(
    parameter int C0_W  = 3,
    parameter int C1_W  = 2,
    parameter int C2_W  = 3,
    parameter int C3_W  = 1,
    parameter int SUM_W = 5
) (
    input  logic [C0_W-1:0]  cnt0_i,
    input  logic [C1_W-1:0]  cnt1_i,
    input  logic [C2_W-1:0]  cnt2_i,
    input  logic [C3_W-1:0]  cnt3_i,
    output logic [SUM_W-1:0] sum_o
);

    logic [SUM_W-1:0] term0, term1, term2, term3;

    // Align each column count to its weight.
    always_comb begin
        term0 = SUM_W'(cnt0_i);
        term1 = SUM_W'(cnt1_i) << 1;
        term2 = SUM_W'(cnt2_i) << 2;
        term3 = SUM_W'(cnt3_i) << 3;
    end

    // Add the aligned terms as two balanced pairs.
    always_comb begin
        sum_o = (term0 + term1) + (term2 + term3);
    end

endmodule

// File: rtl/gpc_out_stage.sv
// Module gpc_out_stage
// Output stage of a counter. It is either a plain wire (REGISTERED = 0)
// or a register with synchronous active-low reset (REGISTERED = 1).
// In the wire form the clock and reset are unused.
module gpc_out_stage #(
    parameter int W          = 5,
    parameter bit REGISTERED = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (REGISTERED) begin : g_reg
            logic [W-1:0] q_r;
            // Capture the sum each cycle; clear it on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_wire
            // Combinational pass of the sum.
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/gpc_counter.sv
// Module gpc_counter
// One generalized parallel counter whose input pattern is picked by KIND.
// Each column is counted separately. The counts are weighted by
// their column position and added. The total can be registered.
// Assumes each COLn_W covers the widest use of that column and that
// SUM_W holds the variant's maximum sum.
module gpc_counter #(
    parameter gpc_pkg::gpc_kind_e KIND = gpc_pkg::GPC_606,
    parameter bit REGISTERED = 1'b0,
    parameter int COL0_W = 6,
    parameter int COL1_W = 2,
    parameter int COL2_W = 6,
    parameter int COL3_W = 1,
    parameter int SUM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL0_W-1:0] col0_i,
    input  logic [COL1_W-1:0] col1_i,
    input  logic [COL2_W-1:0] col2_i,
    input  logic [COL3_W-1:0] col3_i,
    output logic [SUM_W-1:0]  sum_o
);

    localparam int USE0 = gpc_pkg::used_bits(KIND, 0);
    localparam int USE1 = gpc_pkg::used_bits(KIND, 1);
    localparam int USE2 = gpc_pkg::used_bits(KIND, 2);
    localparam int USE3 = gpc_pkg::used_bits(KIND, 3);
    localparam int CW0  = gpc_pkg::cnt_width(USE0);
    localparam int CW1  = gpc_pkg::cnt_width(USE1);
    localparam int CW2  = gpc_pkg::cnt_width(USE2);
    localparam int CW3  = gpc_pkg::cnt_width(USE3);

    logic [CW0-1:0]   cnt0;
    logic [CW1-1:0]   cnt1;
    logic [CW2-1:0]   cnt2;
    logic [CW3-1:0]   cnt3;
    logic [SUM_W-1:0] sum_comb;

    gpc_col_pop #(.IN_W(COL0_W), .USE_W(USE0), .CNT_W(CW0)) u_pop0 (
        .bits_i(col0_i), .cnt_o(cnt0)
    );
    gpc_col_pop #(.IN_W(COL1_W), .USE_W(USE1), .CNT_W(CW1)) u_pop1 (
        .bits_i(col1_i), .cnt_o(cnt1)
    );
    gpc_col_pop #(.IN_W(COL2_W), .USE_W(USE2), .CNT_W(CW2)) u_pop2 (
        .bits_i(col2_i), .cnt_o(cnt2)
    );
    gpc_col_pop #(.IN_W(COL3_W), .USE_W(USE3), .CNT_W(CW3)) u_pop3 (
        .bits_i(col3_i), .cnt_o(cnt3)
    );

    gpc_weight_add #(
        .C0_W(CW0), .C1_W(CW1), .C2_W(CW2), .C3_W(CW3), .SUM_W(SUM_W)
    ) u_add (
        .cnt0_i(cnt0), .cnt1_i(cnt1), .cnt2_i(cnt2), .cnt3_i(cnt3),
        .sum_o(sum_comb)
    );

    gpc_out_stage #(.W(SUM_W), .REGISTERED(REGISTERED)) u_out (
        .clk(clk), .rst_n(rst_n), .d_i(sum_comb), .q_o(sum_o)
    );

endmodule

// File: rtl/gpc_counter_chk.sv
// Module gpc_counter_chk
// Property checker for gpc_counter, attached by bind. It holds its own
// reference sum, built from the variant rules, and compares the port
// value against it, combinationally or one cycle later.
module gpc_counter_chk #(
    parameter gpc_pkg::gpc_kind_e KIND = gpc_pkg::GPC_606,
    parameter bit REGISTERED = 1'b0,
    parameter int COL0_W = 6,
    parameter int COL1_W = 2,
    parameter int COL2_W = 6,
    parameter int COL3_W = 1,
    parameter int SUM_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [COL0_W-1:0] col0_i,
    input logic [COL1_W-1:0] col1_i,
    input logic [COL2_W-1:0] col2_i,
    input logic [COL3_W-1:0] col3_i,
    input logic [SUM_W-1:0]  sum_o
);

    localparam int MAXV = gpc_pkg::max_sum(KIND);

    int ref_sum;
    logic seen_edge;
    logic rst_prev;

    // Reference model: weighted ones count over the used bits.
    always_comb begin
        ref_sum = 0;
        for (int i = 0; i < COL0_W; i++)
            if (i < gpc_pkg::used_bits(KIND, 0) && col0_i[i]) ref_sum += 1;
        for (int i = 0; i < COL1_W; i++)
            if (i < gpc_pkg::used_bits(KIND, 1) && col1_i[i]) ref_sum += 2;
        for (int i = 0; i < COL2_W; i++)
            if (i < gpc_pkg::used_bits(KIND, 2) && col2_i[i]) ref_sum += 4;
        for (int i = 0; i < COL3_W; i++)
            if (i < gpc_pkg::used_bits(KIND, 3) && col3_i[i]) ref_sum += 8;
    end

    // Remember whether reset was applied at the previous edge.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        rst_prev  <= ~rst_n;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sum_o) <= MAXV);

    generate
        if (KIND == gpc_pkg::GPC_PASS) begin : g_pass
            // R4
            pass_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sum_o[SUM_W-1:1] == '0);
        end
        if (REGISTERED) begin : g_reg
            // R7 (also R1 R2 R3 R5 through the reference)
            reg_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> int'(sum_o) == $past(ref_sum));
            // R8
            always_ff @(posedge clk) begin
                if (seen_edge === 1'b1 && rst_prev === 1'b1) begin
                    reset_clear_chk: assert (sum_o == '0);
                end
            end
        end else begin : g_comb
            // R6 (also R1 R2 R3 R5 through the reference)
            comb_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
                int'(sum_o) == ref_sum);
        end
    endgenerate

endmodule

bind gpc_counter gpc_counter_chk #(
    .KIND(KIND), .REGISTERED(REGISTERED),
    .COL0_W(COL0_W), .COL1_W(COL1_W), .COL2_W(COL2_W), .COL3_W(COL3_W),
    .SUM_W(SUM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .col0_i(col0_i), .col1_i(col1_i), .col2_i(col2_i), .col3_i(col3_i),
    .sum_o(sum_o)
);

// File: tb/sim_gpc_counter.sv
// Bench for gpc_counter: five instances share the inputs. u0 is the
// registered (1,4,1,5;5) counter. u1 to u3 are the combinational
// (6,0,6;5), (1,3,2,5;5) and pass-through counters. u4 is the
// registered pass-through.
module sim_gpc_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] c0 = '0;
    logic [1:0] c1 = '0;
    logic [5:0] c2 = '0;
    logic       c3 = 1'b0;
    logic [4:0] s0, s1, s2, s3, s4;

    int n_checks = 0;
    int n_fail = 0;
    int prev_e0, prev_e4;
    bit prev_ok = 1'b0;

    always #5 clk = ~clk;

    gpc_counter #(.KIND(gpc_pkg::GPC_1415), .REGISTERED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .col0_i(c0), .col1_i(c1), .col2_i(c2),
        .col3_i(c3), .sum_o(s0));
    gpc_counter #(.KIND(gpc_pkg::GPC_606), .REGISTERED(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .col0_i(c0), .col1_i(c1), .col2_i(c2),
        .col3_i(c3), .sum_o(s1));
    gpc_counter #(.KIND(gpc_pkg::GPC_1325), .REGISTERED(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .col0_i(c0), .col1_i(c1), .col2_i(c2),
        .col3_i(c3), .sum_o(s2));
    gpc_counter #(.KIND(gpc_pkg::GPC_PASS), .REGISTERED(1'b0)) u3 (
        .clk(clk), .rst_n(rst_n), .col0_i(c0), .col1_i(c1), .col2_i(c2),
        .col3_i(c3), .sum_o(s3));
    gpc_counter #(.KIND(gpc_pkg::GPC_PASS), .REGISTERED(1'b1)) u4 (
        .clk(clk), .rst_n(rst_n), .col0_i(c0), .col1_i(c1), .col2_i(c2),
        .col3_i(c3), .sum_o(s4));

    // Ones count of the low n bits of v.
    function automatic int ones(logic [5:0] v, int n);
        int t = 0;
        for (int i = 0; i < n; i++) t += int'(v[i]);
        return t;
    endfunction

    // Expected sum per variant code, taken from R1 to R4.
    function automatic int expect_sum(int kind, logic [5:0] a, logic [1:0] b,
                                      logic [5:0] c, logic d);
        case (kind)
            0: return ones(a, 6) + 4 * ones(c, 6);
            1: return ones(a, 5) + 2 * int'(b[0]) + 4 * ones(c, 4) + 8 * int'(d);
            2: return ones(a, 5) + 2 * ones({4'b0, b}, 2) + 4 * ones(c, 3) + 8 * int'(d);
            default: return int'(a[0]);
        endcase
    endfunction

    task automatic chk(input string req, input logic [4:0] act, input int exp);
        n_checks++;
        if (act !== 5'(exp)) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Check the registered outputs against the previous vector, drive a new
    // vector, then check the combinational outputs.
    task automatic apply(input logic [5:0] a, input logic [1:0] b,
                         input logic [5:0] c, input logic d, input string tag);
        @(negedge clk);
        if (prev_ok) begin
            chk({"R7 u0 ", tag}, s0, prev_e0);
            chk({"R7 R4 u4 ", tag}, s4, prev_e4);
        end
        c0 = a; c1 = b; c2 = c; c3 = d;
        #1;
        chk({"R1 R6 u1 ", tag}, s1, expect_sum(0, a, b, c, d));
        chk({"R3 R6 u2 ", tag}, s2, expect_sum(2, a, b, c, d));
        chk({"R4 u3 ", tag}, s3, expect_sum(3, a, b, c, d));
        prev_e0 = expect_sum(1, a, b, c, d);
        prev_e4 = expect_sum(3, a, b, c, d);
        prev_ok = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        // R8: reset dominates all-ones inputs.
        c0 = '1; c1 = '1; c2 = '1; c3 = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 u0 in reset", s0, 0);
        chk("R8 u4 in reset", s4, 0);
        rst_n = 1'b1;

        apply('0, '0, '0, 1'b0, "zero");
        // R9: all ones reach each maximum.
        apply('1, '1, '1, 1'b1, "R9 max");
        chk("R9 u1 max", s1, 30);
        chk("R9 u2 max", s2, 29);
        apply('0, '0, '0, 1'b0, "after max");
        // R5: only ignored bits set, per variant.
        apply(6'b000000, 2'b11, 6'b000000, 1'b1, "R5 ign606");
        apply(6'b100000, 2'b10, 6'b110000, 1'b0, "R5 ign1415");
        apply(6'b100000, 2'b00, 6'b111000, 1'b0, "R5 ign1325");
        apply(6'b111110, 2'b11, 6'b111111, 1'b1, "R5 ignpass");
        // R2: single bits of each weight.
        apply(6'b000001, 2'b00, 6'b000000, 1'b0, "R2 w1");
        apply(6'b000000, 2'b01, 6'b000000, 1'b0, "R2 w2");
        apply(6'b000000, 2'b00, 6'b000001, 1'b0, "R2 w4");
        apply(6'b000000, 2'b00, 6'b000000, 1'b1, "R2 w8");
        apply(6'b011111, 2'b01, 6'b001111, 1'b1, "R2 R9 max1415");

        // R8: reset in mid-run with inputs high.
        @(negedge clk);
        chk("R7 u0 pre-reset", s0, prev_e0);
        rst_n = 1'b0; c0 = '1; c1 = '1; c2 = '1; c3 = 1'b1;
        prev_ok = 1'b0;
        @(negedge clk);
        chk("R8 u0 mid reset", s0, 0);
        chk("R8 u4 mid reset", s4, 0);
        rst_n = 1'b1;

        for (int k = 0; k < 400; k++) begin
            apply(6'($urandom), 2'($urandom), 6'($urandom), 1'($urandom), "rand R1 R2 R3");
        end
        apply('0, '0, '0, 1'b0, "flush");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule